// File: doc/BRIEF.md
# Ping-Pong Receive Message Buffer

This block stores incoming message octets in two equal buffers that take turns. Octets arrive on a byte strobe, framed by a start-of-message pulse and an end-of-transfer pulse. Bytes are written in arrival order into whichever buffer is currently filling. At end of transfer, that buffer passes to the processor side, a one-cycle interrupt pulse is raised, and the next message fills the other buffer.

The processor sees three read-only registers on a small sub-address bus. Each buffer has its own data port and no address register. An internal read pointer starts at location 0 when the buffer is handed over and moves forward by one on every read. A count register gives the length of the last completed message in bits 6:0. Its bit 7 names the buffer that holds that message.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, eot_o and ovf_o are 0, and the count register (sub-address 0x5) reads 8'h00.
- R2: Octets are stored in arrival order. The first read of a buffer's data port after its handover returns the first octet of the message, for example 8'h2B in and 8'h2B out. This holds even when the same buffer was partly read during an earlier message.
- R3: Count register bit 7 names the buffer just handed over: 0 for buffer 0 and 1 for buffer 1. The first message fills buffer 0, and successive messages alternate.
- R4: Count register bits 6:0 hold the number of octets stored for the last completed message.
- R5: Each read of data port 0x6 (buffer 0) or 0x7 (buffer 1) returns the octet at that buffer's pointer and then advances the pointer by one. The result appears on rd_data_o one cycle after rd_i.
- R6: Reading a data port past the stored length of its message returns 8'h00.
- R7: Octets beyond DEPTH (96) in one message are dropped and set ovf_o. ovf_o stays set until the next start of message. The stored length saturates at DEPTH.
- R8: eot_o is a single-cycle pulse in the cycle after rx_eot_i.
- R9: From start of message until end of transfer, the data port of the buffer being filled reads 8'h00. A read of any sub-address other than 0x5, 0x6 or 0x7 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_som_i | input | 1 | Start-of-message strobe |
| rx_valid_i | input | 1 | Octet strobe |
| rx_data_i | input | 8 | Received octet |
| rx_eot_i | input | 1 | End-of-transfer strobe |
| rd_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Register sub-address |
| rd_data_o | output | 8 | Read data, registered |
| eot_o | output | 1 | Message-ready interrupt pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the three receive strobes are mutually exclusive in any cycle. They also assume that every message opens with rx_som_i before its first octet. The directed stimulus drives each strobe on a separate cycle and always sends a start pulse before the octet burst. It reads the handed-over buffer only after the interrupt pulse. The overflow case sends more than DEPTH octets inside one well-framed message, so the saturation is checked without breaking these input rules.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  localparam logic [3:0] ADDR_CNT  = 4'h5;
  localparam logic [3:0] ADDR_BUF0 = 4'h6;
  localparam logic [3:0] ADDR_BUF1 = 4'h7;
  localparam int unsigned NUM_BUF  = 2;
endpackage

// File: rtl/rpb_bank.sv
module rpb_bank #(
  parameter int unsigned DEPTH = 96,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_len_i,
  input  logic          rd_en_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] ptr_q, len_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      ptr_q <= '0;
      len_q <= load_len_i;
    end else if (clr_i) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (rd_en_i && ptr_q < CW'(DEPTH)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // past the stored length the port reads zero
  assign rd_data_o = (ptr_q < len_q) ? mem_q[ptr_q[AW-1:0]] : 8'h00;
endmodule

// File: rtl/rpb_wr_ctrl.sv
module rpb_wr_ctrl #(
  parameter int unsigned DEPTH = 96,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          som_i,
  input  logic          valid_i,
  input  logic          eot_i,
  output logic [1:0]    wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [1:0]    clr_o,
  output logic [1:0]    load_o,
  output logic [CW-1:0] load_len_o,
  output logic          fill_sel_o,
  output logic          ready_sel_o,
  output logic [CW-1:0] msg_len_o,
  output logic          eot_o,
  output logic          ovf_o
);
  logic          fill_q, ready_q, eot_q, ovf_q;
  logic [CW-1:0] cnt_q, msg_len_q;
  logic          room;

  assign room = cnt_q < CW'(DEPTH);

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      wr_en_o[b] = valid_i && room && (fill_q == b[0]);
      clr_o[b]   = som_i && (fill_q == b[0]);
      load_o[b]  = eot_i && (fill_q == b[0]);
    end
  end

  assign wr_addr_o  = cnt_q[AW-1:0];
  assign load_len_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q    <= 1'b0;
      ready_q   <= 1'b0;
      cnt_q     <= '0;
      msg_len_q <= '0;
      eot_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      eot_q <= eot_i;
      if (eot_i) begin
        ready_q   <= fill_q;
        msg_len_q <= cnt_q;
        fill_q    <= ~fill_q;
        cnt_q     <= '0;
      end else if (som_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (valid_i) begin
        if (room) cnt_q <= cnt_q + 1'b1;
        else      ovf_q <= 1'b1;
      end
    end
  end

  assign fill_sel_o  = fill_q;
  assign ready_sel_o = ready_q;
  assign msg_len_o   = msg_len_q;
  assign eot_o       = eot_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
  parameter int unsigned DEPTH = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_som_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_eot_i,
  input  logic       rd_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       eot_o,
  output logic       ovf_o
);
  import rpb_pkg::*;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [1:0]    wr_en, clr, load, rd_en;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] load_len, msg_len;
  logic          fill_sel, ready_sel;
  logic [7:0]    bank_data [NUM_BUF];
  logic [7:0]    rd_data_q, rd_next;
  logic [7:0]    cnt_reg;

  rpb_wr_ctrl #(.DEPTH(DEPTH)) i_wr_ctrl (
    .clk_i, .rst_ni,
    .som_i(rx_som_i), .valid_i(rx_valid_i), .eot_i(rx_eot_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .clr_o(clr), .load_o(load),
    .load_len_o(load_len), .fill_sel_o(fill_sel), .ready_sel_o(ready_sel),
    .msg_len_o(msg_len), .eot_o(eot_o), .ovf_o(ovf_o)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
    assign rd_en[b] = rd_i && (rd_addr_i == ADDR_BUF0 + 4'(b));
    rpb_bank #(.DEPTH(DEPTH)) i_bank (
      .clk_i, .rst_ni,
      .wr_en_i(wr_en[b]), .wr_addr_i(wr_addr), .wr_data_i(rx_data_i),
      .clr_i(clr[b]), .load_i(load[b]), .load_len_i(load_len),
      .rd_en_i(rd_en[b]), .rd_data_o(bank_data[b])
    );
  end

  assign cnt_reg = {ready_sel, 7'(msg_len)};

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CNT:  rd_next = cnt_reg;
      ADDR_BUF0: rd_next = bank_data[0];
      ADDR_BUF1: rd_next = bank_data[1];
      default:   rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_q <= 8'h00;
    else if (rd_i) rd_data_q <= rd_next;
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
  parameter int unsigned DEPTH = 96,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_som_i,
  input logic          rx_valid_i,
  input logic          rx_eot_i,
  input logic          rd_i,
  input logic [3:0]    rd_addr_i,
  input logic [7:0]    rd_data_o,
  input logic          eot_o,
  input logic          ovf_o,
  input logic          fill_sel,
  input logic          ready_sel,
  input logic [CW-1:0] msg_len
);
  assert_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rx_som_i, rx_valid_i, rx_eot_i}) <= 1);

  assert_eot_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_eot_i |=> eot_o);

  assert_eot_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_eot_i |=> !eot_o);

  assert_ready_other_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_o |-> ready_sel != fill_sel);

  assert_len_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_len <= CW'(DEPTH));

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !rx_som_i) |=> ovf_o);

  assert_ovf_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_som_i |=> !ovf_o);

  assert_bad_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_addr_i != 4'h5 && rd_addr_i != 4'h6 && rd_addr_i != 4'h7)
      |=> rd_data_o == 8'h00);

  assert_rd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
endmodule

bind rx_pingpong_buf rpb_checker #(.DEPTH(DEPTH)) i_rpb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_som_i(rx_som_i), .rx_valid_i(rx_valid_i),
  .rx_eot_i(rx_eot_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .eot_o(eot_o), .ovf_o(ovf_o), .fill_sel(fill_sel), .ready_sel(ready_sel),
  .msg_len(msg_len)
);

// File: tb/test_rx_pingpong_buf.sv
module test_rx_pingpong_buf;
  localparam int DEPTH = 96;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_som_i = 1'b0, rx_valid_i = 1'b0, rx_eot_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic [3:0] rd_addr_i = 4'h0;
  logic [7:0] rd_data_o;
  logic       eot_o, ovf_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rx_pingpong_buf #(.DEPTH(DEPTH)) i_rx_pingpong_buf (.*);

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return base ^ 8'(i * 13);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic send_msg(input int n, input logic [7:0] base);
    rx_som_i = 1'b1; @(negedge clk_i); rx_som_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1'b1; rx_data_i = pat(base, i);
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0;
    rx_eot_i = 1'b1; @(negedge clk_i); rx_eot_i = 1'b0;
    check("R8 pulse", {7'b0, eot_o}, 8'h01);
    @(negedge clk_i);
    check("R8 single", {7'b0, eot_o}, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 eot", {7'b0, eot_o}, 8'h00);
    check("R1 ovf", {7'b0, ovf_o}, 8'h00);
    rd(4'h5, d); check("R1 count", d, 8'h00);
  endtask

  task automatic t_first;
    logic [7:0] d;
    send_msg(5, 8'h2B);
    rd(4'h5, d); check("R3 R4 count msg1", d, 8'h05);
    rd(4'h6, d); check("R2 first octet", d, 8'h2B);
    for (int i = 1; i < 5; i++) begin
      rd(4'h6, d); check("R5 sequential", d, pat(8'h2B, i));
    end
    rd(4'h6, d); check("R6 past length", d, 8'h00);
    rd(4'h6, d); check("R6 past length 2", d, 8'h00);
  endtask

  task automatic t_second;
    logic [7:0] d;
    send_msg(3, 8'hC4);
    rd(4'h5, d); check("R3 R4 count msg2", d, 8'h83);
    for (int i = 0; i < 3; i++) begin
      rd(4'h7, d); check("R5 buf1 read", d, pat(8'hC4, i));
    end
    rd(4'h7, d); check("R6 buf1 past length", d, 8'h00);
  endtask

  task automatic t_refill;
    logic [7:0] d;
    // buffer 0 partly read beforehand; refill must restart at location 0
    rx_som_i = 1'b1; @(negedge clk_i); rx_som_i = 1'b0;
    rx_valid_i = 1'b1; rx_data_i = pat(8'h5A, 0); @(negedge clk_i);
    rx_valid_i = 1'b0;
    rd(4'h6, d); check("R9 filling buffer", d, 8'h00);
    rx_valid_i = 1'b1; rx_data_i = pat(8'h5A, 1); @(negedge clk_i);
    rx_valid_i = 1'b0;
    rx_eot_i = 1'b1; @(negedge clk_i); rx_eot_i = 1'b0;
    @(negedge clk_i);
    rd(4'h5, d); check("R3 count msg3", d, 8'h02);
    rd(4'h6, d); check("R2 refill location 0", d, pat(8'h5A, 0));
    rd(4'h6, d); check("R5 refill second", d, pat(8'h5A, 1));
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    send_msg(DEPTH + 4, 8'h91);
    check("R7 ovf set", {7'b0, ovf_o}, 8'h01);
    rd(4'h5, d); check("R7 R4 saturated count", d, 8'h80 | 8'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'h7, d);
      if (i == 0 || i == DEPTH - 1) check("R7 kept octet", d, pat(8'h91, i));
    end
    rd(4'h7, d); check("R7 R6 dropped octet", d, 8'h00);
    rx_som_i = 1'b1; @(negedge clk_i); rx_som_i = 1'b0;
    check("R7 ovf cleared", {7'b0, ovf_o}, 8'h00);
    rx_eot_i = 1'b1; @(negedge clk_i); rx_eot_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_bad_addr;
    logic [7:0] d;
    rd(4'h3, d); check("R9 unmapped 0x3", d, 8'h00);
    rd(4'hF, d); check("R9 unmapped 0xF", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first();
    t_second();
    t_refill();
    t_overflow();
    t_bad_addr();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule